// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events and clock cycles so that software can measure how a processor core behaves. It holds three 32-bit event counters and one 32-bit cycle counter. Each event counter takes one of eight single-cycle event pulse inputs, chosen by its own event-type field. Software reaches all registers through a small synchronous register port. The three event counters have no addresses of their own. They share one data window and one type window, and a select register chooses which counter those windows reach.

Event counting only happens when at least one of the two debug-authentication inputs is high. The cycle counter ignores those inputs unless the control register's debug-prohibit bit is set. In that case it is gated in the same way as the event counters. Every counter has an enable bit, a sticky overflow flag and an overflow interrupt enable. The interrupt output is raised whenever a flag is set and its enable is set. No halt or run state of the core masks it.

The control register holds a global enable, a user-access bit, the debug-prohibit bit, and a divide option that makes the cycle counter advance once every 64 counted clocks. It also holds two self-clearing reset strobes: one clears the cycle counter and one clears all event counters.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset all counters, counter enables, overflow flags, interrupt enables, select and event types are zero and `pmuIrq` is low. The control word (address 0) reads the number of event counters, 3, in bits [15:11].
- R2: Counter enable masks use bit 0..2 for the event counters and bit 31 for the cycle counter. Writing 1s to address 1 sets enable bits and writing 1s to address 2 clears them. Other bits are unchanged, and both addresses read back the current mask. A disabled counter does not advance.
- R3: With global enable (control bit 0) set, an enabled event counter whose type code (address 8, bits [7:0]) is 0..7 increments by one in each cycle its `eventIn[code]` is high. A code of 8 or more never counts.
- R4: Event counters advance only while `dbgEn` or `niDbgEn` is high. With both low they hold their value.
- R5: With control bit 4 (debug prohibit) clear, the cycle counter advances every cycle it is globally enabled and enabled, whatever the debug inputs are. With bit 4 set, it also needs `dbgEn` or `niDbgEn` high.
- R6: The select register (address 6) picks event counter 0..2 for the data window (address 7) and the type window (address 8). A select value of 3 makes both windows read 0 and ignore writes.
- R7: Writing control bit 1 clears all event counters, and writing control bit 2 clears the cycle counter and its prescaler. Both bits read back as 0. A reset beats an increment or a data write in the same cycle.
- R8: With control bit 3 set, the cycle counter advances once after every 64 counted cycles (the 64th, 128th, ... since its reset).
- R9: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its overflow flag on the same edge. Flags read at address 5 (bits 0..2 events, bit 31 cycle) and clear by writing 1. A new overflow beats a clear in the same cycle.
- R10: `pmuIrq` is high exactly when some overflow flag is set together with its interrupt enable. Interrupt enables are set at address 3 and cleared at address 4, with the same bit layout as R2.
- R11: `regRdData` shows, one clock after an address is presented, the register value as it stood before that edge. A data write to a counter (address 7 or 9) takes effect at that edge and beats an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| eventIn | input | 8 | Single-cycle event pulses |
| dbgEn | input | 1 | Invasive debug authentication |
| niDbgEn | input | 1 | Non-invasive debug authentication |
| pmuIrq | output | 1 | Overflow interrupt request |

## Verification
Two functions collide at the same edge: a software update of counter state and the counter's own increment. The cases are a wrap racing a write-1-to-clear of the same flag, a data write racing an event, and a reset strobe racing an event. The bench provokes each one by driving the event pulse in the same cycle as the register write. It then reads back through the port: the flag must remain set, the written value must stand, and the reset must leave zero. The event-counting phase uses random event patterns and random debug-input values from a fixed seed. Its results are compared with counts the bench accumulates from those same inputs.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  parameter int REG_W      = 32;
  parameter int CNT_W      = REG_W;
  parameter int N_EVT      = 3;
  parameter int N_SRC      = 8;
  parameter int TYPE_W     = 8;
  parameter int ADDR_W     = 4;
  parameter int DIV_RATIO  = 64;
  parameter int NUM_W      = 5;

  localparam int SEL_W   = $clog2(N_EVT);
  localparam int SRC_W   = $clog2(N_SRC);
  localparam int PRE_W   = $clog2(DIV_RATIO);
  localparam int CYC_BIT = REG_W - 1;

  // control word bit positions
  localparam int CB_GEN   = 0;
  localparam int CB_ERST  = 1;
  localparam int CB_CRST  = 2;
  localparam int CB_DIV   = 3;
  localparam int CB_PROH  = 4;
  localparam int CB_USER  = 5;
  localparam int NUM_LSB  = 11;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_ENSET  = 4'd1,
    A_ENCLR  = 4'd2,
    A_IRQSET = 4'd3,
    A_IRQCLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_EVDATA = 4'd7,
    A_EVTYPE = 4'd8,
    A_CYC    = 4'd9
  } regAddr_e;

  typedef struct packed {
    logic                         globalEn;
    logic                         div64;
    logic                         dbgProhibit;
    logic [N_EVT:0]               cntEn;
    logic [N_EVT:0]               irqEn;
    logic [N_EVT-1:0][TYPE_W-1:0] evType;
  } cfg_t;

  typedef struct packed {
    logic             evtRst;
    logic             cycRst;
    logic [N_EVT-1:0] evtWr;
    logic             cycWr;
    logic [N_EVT:0]   ovfClr;
    logic [REG_W-1:0] wrData;
  } strobe_t;

  function automatic logic [N_EVT:0] regToMask(input logic [REG_W-1:0] r);
    regToMask = {r[CYC_BIT], r[N_EVT-1:0]};
  endfunction

  function automatic logic [REG_W-1:0] maskToReg(input logic [N_EVT:0] m);
    logic [REG_W-1:0] r;
    r = '0;
    r[N_EVT-1:0] = m[N_EVT-1:0];
    r[CYC_BIT]   = m[N_EVT];
    maskToReg = r;
  endfunction
endpackage

// File: rtl/pcu_ctrl.sv
`timescale 1ns/1ps
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         regWrEn,
  input  logic [REG_W-1:0]             regWrData,
  input  logic [N_EVT-1:0][CNT_W-1:0]  evCnt,
  input  logic [CNT_W-1:0]             cycCnt,
  input  logic [N_EVT:0]               ovf,
  output cfg_t                         cfg,
  output strobe_t                      strb,
  output logic [REG_W-1:0]             regRdData
);
  logic                         globalEn, div64, prohibit, userEn;
  logic [N_EVT:0]               cntEn, irqEn;
  logic [SEL_W-1:0]             sel;
  logic [N_EVT-1:0][TYPE_W-1:0] evType;
  logic                         selValid;
  logic [REG_W-1:0]             rdNext, ctrlWord, selData, selType;

  assign selValid = (sel < SEL_W'(N_EVT));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      div64    <= 1'b0;
      prohibit <= 1'b0;
      userEn   <= 1'b0;
      cntEn    <= '0;
      irqEn    <= '0;
      sel      <= '0;
      evType   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL: begin
          globalEn <= regWrData[CB_GEN];
          div64    <= regWrData[CB_DIV];
          prohibit <= regWrData[CB_PROH];
          userEn   <= regWrData[CB_USER];
        end
        A_ENSET:  cntEn <= cntEn | regToMask(regWrData);
        A_ENCLR:  cntEn <= cntEn & ~regToMask(regWrData);
        A_IRQSET: irqEn <= irqEn | regToMask(regWrData);
        A_IRQCLR: irqEn <= irqEn & ~regToMask(regWrData);
        A_SEL:    sel   <= regWrData[SEL_W-1:0];
        A_EVTYPE: begin
          for (int k = 0; k < N_EVT; k++) begin
            if (sel == SEL_W'(k)) evType[k] <= regWrData[TYPE_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // strobes toward the datapath
  always_comb begin
    strb        = '0;
    strb.wrData = regWrData;
    if (regWrEn) begin
      case (regAddr)
        A_CTRL: begin
          strb.evtRst = regWrData[CB_ERST];
          strb.cycRst = regWrData[CB_CRST];
        end
        A_OVF:  strb.ovfClr = regToMask(regWrData);
        A_CYC:  strb.cycWr  = 1'b1;
        A_EVDATA: begin
          for (int k = 0; k < N_EVT; k++) begin
            strb.evtWr[k] = (sel == SEL_W'(k));
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.globalEn    = globalEn;
    cfg.div64       = div64;
    cfg.dbgProhibit = prohibit;
    cfg.cntEn       = cntEn;
    cfg.irqEn       = irqEn;
    cfg.evType      = evType;
  end

  // banked window selection
  always_comb begin
    selData = '0;
    selType = '0;
    for (int k = 0; k < N_EVT; k++) begin
      if (selValid && sel == SEL_W'(k)) begin
        selData            = evCnt[k];
        selType[TYPE_W-1:0] = evType[k];
      end
    end
  end

  always_comb begin
    ctrlWord                       = '0;
    ctrlWord[CB_GEN]               = globalEn;
    ctrlWord[CB_DIV]               = div64;
    ctrlWord[CB_PROH]              = prohibit;
    ctrlWord[CB_USER]              = userEn;
    ctrlWord[NUM_LSB +: NUM_W]     = NUM_W'(N_EVT);
  end

  always_comb begin
    rdNext = '0;
    case (regAddr)
      A_CTRL:             rdNext = ctrlWord;
      A_ENSET, A_ENCLR:   rdNext = maskToReg(cntEn);
      A_IRQSET, A_IRQCLR: rdNext = maskToReg(irqEn);
      A_OVF:              rdNext = maskToReg(ovf);
      A_SEL:              rdNext[SEL_W-1:0] = sel;
      A_EVDATA:           rdNext = selData;
      A_EVTYPE:           rdNext = selType;
      A_CYC:              rdNext = cycCnt;
      default:            rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdNext;
  end
endmodule

// File: rtl/pcu_datapath.sv
`timescale 1ns/1ps
module pcu_datapath
  import pcu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  cfg_t                         cfg,
  input  strobe_t                      strb,
  input  logic [N_SRC-1:0]             eventIn,
  input  logic                         dbgEn,
  input  logic                         niDbgEn,
  output logic [N_EVT-1:0][CNT_W-1:0]  evCnt,
  output logic [CNT_W-1:0]             cycCnt,
  output logic [N_EVT:0]               ovf,
  output logic                         irq
);
  logic evtAuth, cycAuth;

  assign evtAuth = dbgEn | niDbgEn;
  assign cycAuth = cfg.dbgProhibit ? evtAuth : 1'b1;

  for (genvar i = 0; i < N_EVT; i++) begin : gEvt
    logic [CNT_W-1:0] cntQ;
    logic             flagQ, hit, inc, wrap;

    assign hit  = (cfg.evType[i] < TYPE_W'(N_SRC)) &&
                  eventIn[cfg.evType[i][SRC_W-1:0]];
    assign inc  = cfg.globalEn && cfg.cntEn[i] && evtAuth && hit;
    assign wrap = inc && (cntQ == '1) && !strb.evtRst && !strb.evtWr[i];

    always_ff @(posedge clk) begin
      if (!rstN)              cntQ <= '0;
      else if (strb.evtRst)   cntQ <= '0;
      else if (strb.evtWr[i]) cntQ <= strb.wrData[CNT_W-1:0];
      else if (inc)           cntQ <= cntQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)               flagQ <= 1'b0;
      else if (wrap)           flagQ <= 1'b1;
      else if (strb.ovfClr[i]) flagQ <= 1'b0;
    end

    assign evCnt[i] = cntQ;
    assign ovf[i]   = flagQ;
  end

  logic [PRE_W-1:0] preQ;
  logic             cycActive, tick, cycWrap, cycFlagQ;

  assign cycActive = cfg.globalEn && cfg.cntEn[N_EVT] && cycAuth;
  assign tick      = cycActive && (!cfg.div64 || preQ == PRE_W'(DIV_RATIO - 1));
  assign cycWrap   = tick && (cycCnt == '1) && !strb.cycRst && !strb.cycWr;

  always_ff @(posedge clk) begin
    if (!rstN)                         preQ <= '0;
    else if (strb.cycRst)              preQ <= '0;
    else if (cycActive && cfg.div64)   preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cycCnt <= '0;
    else if (strb.cycRst) cycCnt <= '0;
    else if (strb.cycWr)  cycCnt <= strb.wrData[CNT_W-1:0];
    else if (tick)        cycCnt <= cycCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   cycFlagQ <= 1'b0;
    else if (cycWrap)            cycFlagQ <= 1'b1;
    else if (strb.ovfClr[N_EVT]) cycFlagQ <= 1'b0;
  end

  assign ovf[N_EVT] = cycFlagQ;
  assign irq        = |(ovf & cfg.irqEn);
endmodule

// File: rtl/perf_counter_unit.sv
`timescale 1ns/1ps
module perf_counter_unit
  import pcu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [N_SRC-1:0]   eventIn,
  input  logic               dbgEn,
  input  logic               niDbgEn,
  output logic               pmuIrq
);
  cfg_t                        cfg;
  strobe_t                     strb;
  logic [N_EVT-1:0][CNT_W-1:0] evCnt;
  logic [CNT_W-1:0]            cycCnt;
  logic [N_EVT:0]              ovf;

  pcu_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .evCnt     (evCnt),
    .cycCnt    (cycCnt),
    .ovf       (ovf),
    .cfg       (cfg),
    .strb      (strb),
    .regRdData (regRdData)
  );

  pcu_datapath dpI (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .strb    (strb),
    .eventIn (eventIn),
    .dbgEn   (dbgEn),
    .niDbgEn (niDbgEn),
    .evCnt   (evCnt),
    .cycCnt  (cycCnt),
    .ovf     (ovf),
    .irq     (pmuIrq)
  );
endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker
  import pcu_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        dbgEn,
  input logic                        niDbgEn,
  input strobe_t                     strb,
  input logic [N_EVT-1:0][CNT_W-1:0] evCnt,
  input logic [CNT_W-1:0]            cycCnt,
  input logic [N_EVT:0]              ovf
);
  AST_EVT_HOLD_NOAUTH: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgEn && !niDbgEn && !strb.evtRst && strb.evtWr == '0) |=> $stable(evCnt)); // R4

  AST_EVT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.evtRst |=> (evCnt == '0)); // R7

  AST_CYC_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.cycRst |=> (cycCnt == '0)); // R7

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cycRst && !strb.cycWr) |=>
      (cycCnt == $past(cycCnt) || cycCnt == $past(cycCnt) + 1'b1)); // R8

  AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt == '1 && !strb.cycRst && !strb.cycWr) |=>
      (cycCnt == '1 || (cycCnt == '0 && ovf[N_EVT]))); // R9

  for (genvar i = 0; i < N_EVT; i++) begin : gChk
    AST_EVT_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (evCnt[i] == '1 && !strb.evtRst && !strb.evtWr[i]) |=>
        (evCnt[i] == '1 || (evCnt[i] == '0 && ovf[i]))); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (ovf[i] && !strb.ovfClr[i]) |=> ovf[i]); // R9
  end
endmodule

bind perf_counter_unit pcu_checker chkI (
  .clk     (clk),
  .rstN    (rstN),
  .dbgEn   (dbgEn),
  .niDbgEn (niDbgEn),
  .strb    (strb),
  .evCnt   (evCnt),
  .cycCnt  (cycCnt),
  .ovf     (ovf)
);

// File: tb/perf_counter_unit_tb_top.sv
`timescale 1ns/1ps
module perf_counter_unit_tb_top;
  localparam logic [3:0] CTRL = 4'd0, ENSET = 4'd1, ENCLR = 4'd2, IRQSET = 4'd3,
                         IRQCLR = 4'd4, OVF = 4'd5, SEL = 4'd6, EVDATA = 4'd7,
                         EVTYPE = 4'd8, CYC = 4'd9;
  localparam logic [31:0] NUM_FIELD = 32'd3 << 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  eventIn = '0;
  logic        dbgEn = 1'b0;
  logic        niDbgEn = 1'b0;
  logic        pmuIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_counter_unit dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .eventIn(eventIn),
    .dbgEn(dbgEn), .niDbgEn(niDbgEn), .pmuIrq(pmuIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wrEv(input logic [3:0] a, input logic [31:0] d, input logic [7:0] ev);
    regAddr = a; regWrData = d; regWrEn = 1'b1; eventIn = ev;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; eventIn = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEv(a, d, 8'h00);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    regAddr = a; regWrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] countOf(input logic [31:0] prev, input logic [7:0] code,
                                          input logic [7:0] ev, input logic auth);
    if (auth && code < 8 && ev[code[2:0]]) return prev + 1;
    return prev;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] model [3];
    logic [7:0]  codes [3];
    void'($urandom(32'd715));
    codes[0] = 8'd2; codes[1] = 8'd5; codes[2] = 8'd9;
    for (int i = 0; i < 3; i++) model[i] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(CTRL, v);   check("R1 ctrl", v, NUM_FIELD);
    rd(ENSET, v);  check("R1 enables", v, 32'h0);
    rd(OVF, v);    check("R1 flags", v, 32'h0);
    rd(CYC, v);    check("R1 cycle", v, 32'h0);
    check("R1 irq", {31'd0, pmuIrq}, 32'h0);

    // R2 set/clear masks
    wr(ENSET, 32'h8000_0005);
    rd(ENSET, v);  check("R2 set", v, 32'h8000_0005);
    wr(ENCLR, 32'h8000_0001);
    rd(ENCLR, v);  check("R2 clear", v, 32'h0000_0004);
    wr(ENCLR, 32'hFFFF_FFFF);

    // R6 type programming through the banked window
    for (int i = 0; i < 3; i++) begin
      wr(SEL, i);
      wr(EVTYPE, {24'd0, codes[i]});
    end
    wr(SEL, 32'd1);
    rd(EVTYPE, v); check("R6 type bank1", v, 32'd5);
    wr(ENSET, 32'h0000_0007);
    wr(CTRL, 32'h3);

    // R3 R4 random counting phase
    for (int c = 0; c < 400; c++) begin
      logic auth;
      eventIn = 8'($urandom);
      dbgEn   = ($urandom % 4) == 0;
      niDbgEn = ($urandom % 3) == 0;
      auth    = dbgEn | niDbgEn;
      @(posedge clk);
      for (int i = 0; i < 3; i++) model[i] = countOf(model[i], codes[i], eventIn, auth);
      @(negedge clk);
    end
    eventIn = '0; dbgEn = 1'b0; niDbgEn = 1'b0;
    wr(CTRL, 32'h0);
    wr(SEL, 32'd0); rd(EVDATA, v); check("R3 R4 counter0", v, model[0]);
    wr(SEL, 32'd1); rd(EVDATA, v); check("R3 R4 counter1", v, model[1]);
    wr(SEL, 32'd2); rd(EVDATA, v); check("R3 unsupported code", v, 32'd0);

    // R6 select 3 reads zero and ignores writes
    wr(SEL, 32'd3);
    wr(EVDATA, 32'h1234);
    rd(EVDATA, v); check("R6 sel3 read", v, 32'd0);
    wr(SEL, 32'd1);
    rd(EVDATA, v); check("R6 sel3 write ignored", v, model[1]);

    // R9 R10 event overflow
    dbgEn = 1'b1;
    wr(SEL, 32'd0);
    wr(EVDATA, 32'hFFFF_FFFE);
    wr(IRQSET, 32'h1);
    wr(CTRL, 32'h1);
    wrEv(SEL, 32'd0, 8'h04);
    rd(OVF, v);    check("R9 no flag before wrap", v, 32'h0);
    check("R10 irq low", {31'd0, pmuIrq}, 32'h0);
    wrEv(SEL, 32'd0, 8'h04);
    check("R10 irq on overflow", {31'd0, pmuIrq}, 32'h1);
    rd(EVDATA, v); check("R9 wrap to zero", v, 32'h0);
    rd(OVF, v);    check("R9 flag set", v, 32'h1);

    // R9 new overflow beats clear in the same cycle
    wr(EVDATA, 32'hFFFF_FFFF);
    wrEv(OVF, 32'h1, 8'h04);
    rd(OVF, v);    check("R9 set beats clear", v, 32'h1);
    wr(OVF, 32'h1);
    rd(OVF, v);    check("R9 w1c", v, 32'h0);
    check("R10 irq cleared", {31'd0, pmuIrq}, 32'h0);

    // R11 write beats increment, R7 reset beats increment
    wrEv(EVDATA, 32'd5, 8'h04);
    rd(EVDATA, v); check("R11 write beats inc", v, 32'd5);
    wrEv(CTRL, 32'h3, 8'h04);
    rd(EVDATA, v); check("R7 reset beats inc", v, 32'd0);
    rd(CTRL, v);   check("R7 strobe self clears", v, NUM_FIELD | 32'h1);

    // R2 disabled counter does not advance
    wr(ENCLR, 32'h1);
    wrEv(SEL, 32'd0, 8'h04);
    rd(EVDATA, v); check("R2 disabled holds", v, 32'd0);

    // R5 cycle counter gating
    dbgEn = 1'b0;
    wr(ENSET, 32'h8000_0000);
    wr(CTRL, 32'h5);
    idle(100);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R5 free running", v, 32'd101);
    wr(CTRL, 32'h15);
    idle(50);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R5 prohibit blocks", v, 32'd0);
    niDbgEn = 1'b1;
    wr(CTRL, 32'h15);
    idle(20);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R5 prohibit with auth", v, 32'd21);
    niDbgEn = 1'b0;

    // R8 divide by 64, R7 prescaler reset
    wr(CTRL, 32'hD);
    idle(200);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R8 divided count", v, 32'd3);
    wr(CTRL, 32'hD);
    idle(62);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R7 prescaler cleared", v, 32'd0);

    // R9 R10 cycle overflow and mask
    wr(CTRL, 32'h1);
    wr(CYC, 32'hFFFF_FFFF);
    wr(CTRL, 32'h0);
    rd(CYC, v);    check("R9 cycle wrap", v, 32'd0);
    rd(OVF, v);    check("R9 cycle flag", v, 32'h8000_0000);
    check("R10 masked", {31'd0, pmuIrq}, 32'h0);
    wr(IRQSET, 32'h8000_0000);
    check("R10 unmasked", {31'd0, pmuIrq}, 32'h1);
    wr(IRQCLR, 32'h8000_0000);
    rd(IRQSET, v); check("R10 enable clear", v, 32'h1);
    check("R10 irq after clear", {31'd0, pmuIrq}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule